// File: doc/BRIEF.md
# Network Function Configuration Header with I/O Window Decode

This block holds the handful of configuration-space bytes that identify a single-function network device, and the base register of its I/O window. Configuration reads and writes come in one byte at a time, each with its own byte offset. The identity bytes are fixed: writes to them are dropped. The I/O base register holds the upper address bits of a 32-byte window, and the host can program those bits.

The same base register drives a live comparator on the bus side. While the I/O-space enable input is high, an address-phase strobe that carries an I/O read or I/O write command raises the hit output in that same cycle, provided the upper bus address matches the programmed base. A device front end uses this hit to claim the access. Any other bus protocol handling is done outside this block.

Top module: `cfg_io_hdr`

## Requirements
- R1: After the active-low asynchronous reset, `cfg_rdata_o` is 00h, the programmable base bits are all zero (offsets 10h..13h read 01h, 00h, 00h, 00h) and `io_hit_o` stays low until a hit condition occurs.
- R2: The identity bytes read fixed values and ignore writes: offset 09h (programming interface) reads 00h, offset 0Ah (sub-class, Ethernet) reads 00h, and offset 0Bh (base class, network) reads 02h.
- R3: Offset 0Eh (header type) reads 00h, with bit 7 = 0 for a single function and bits 6:0 = 0 for the standard layout. Writes to it have no effect.
- R4: The I/O base occupies offsets 10h..13h. The byte at 10h+n holds base bits 8n+7..8n. Base bits 31:5 are writable and read back the last value written.
- R5: Base bits 4:1 always read 0 and bit 0 always reads 1 (I/O-space marker). Writes to these bits have no effect.
- R6: A read of any offset other than 09h, 0Ah, 0Bh, 0Eh and 10h..13h returns 00h. A write to such an offset changes no register.
- R7: `cfg_rdata_o` carries the addressed byte in the cycle after `cfg_rd_i` is sampled high. It is 00h in any cycle that does not follow a sampled read. A read in the same cycle as a write sees the value from before the write.
- R8: `io_hit_o` is high in the same cycle when `addr_phase_i` and `io_en_i` are both high, `bus_cmd_i` is I/O read (4'b0010) or I/O write (4'b0011), and `bus_addr_i` (address bits 31:5) equals the programmed base bits.
- R9: `io_hit_o` stays low whenever `io_en_i` is low, whatever the address and command.
- R10: `io_hit_o` stays low for every command other than 4'b0010 and 4'b0011, including memory (4'b0110, 4'b0111) and configuration (4'b1010, 4'b1011) commands.
- R11: `io_hit_o` is never high in a cycle where `addr_phase_i` is low, so a hit lasts exactly as long as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write byte |
| cfg_rdata_o | output | 8 | Registered configuration read byte |
| bus_addr_i | input | 27 | Bus address bits 31:5 |
| bus_cmd_i | input | 4 | Bus command code |
| addr_phase_i | input | 1 | Address-phase strobe |
| io_en_i | input | 1 | I/O-space decode enable |
| io_hit_o | output | 1 | I/O window hit, same cycle as the strobe |

## Verification
The assertions assume that `cfg_rd_i` and `cfg_wr_i` are single-cycle strobes. They also assume that the bus command and address are meaningful only while `addr_phase_i` is high. They do not cover a read and a write to the same offset in the same cycle. The stimulus drives each configuration access as a one-cycle pulse and never issues a read and a write together. It draws offsets from the implemented set mixed with random bytes. Half of its bus addresses are aimed at the programmed base, so that hits and near misses both occur under every combination of enable, strobe and command.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam logic [7:0] OFF_PIF     = 8'h09;
  localparam logic [7:0] OFF_SUBCLS  = 8'h0A;
  localparam logic [7:0] OFF_BASECLS = 8'h0B;
  localparam logic [7:0] OFF_HDRTYPE = 8'h0E;
  localparam logic [7:0] OFF_IOBAR   = 8'h10;

  localparam logic [7:0] VAL_PIF     = 8'h00;
  localparam logic [7:0] VAL_SUBCLS  = 8'h00;
  localparam logic [7:0] VAL_BASECLS = 8'h02;
  localparam logic [7:0] VAL_HDRTYPE = 8'h00;

  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'b0010,
    CMD_IO_WR  = 4'b0011,
    CMD_MEM_RD = 4'b0110,
    CMD_MEM_WR = 4'b0111,
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } bus_cmd_e;

  function automatic logic is_io_cmd(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
  endfunction
endpackage

// File: rtl/cfg_id_rom.sv
module cfg_id_rom
  import cfg_hdr_pkg::*;
#(
  parameter logic [7:0] PIF     = VAL_PIF,
  parameter logic [7:0] SUBCLS  = VAL_SUBCLS,
  parameter logic [7:0] BASECLS = VAL_BASECLS,
  parameter logic [7:0] HDRTYPE = VAL_HDRTYPE
) (
  input  logic [7:0] addr_i,
  output logic       sel_o,
  output logic [7:0] data_o
);
  always_comb begin
    sel_o  = 1'b1;
    data_o = 8'h00;
    unique case (addr_i)
      OFF_PIF:     data_o = PIF;
      OFF_SUBCLS:  data_o = SUBCLS;
      OFF_BASECLS: data_o = BASECLS;
      OFF_HDRTYPE: data_o = HDRTYPE;
      default:     sel_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_iobar_reg.sv
module cfg_iobar_reg
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                addr_i,
  input  logic                      wr_i,
  input  logic [7:0]                wdata_i,
  output logic                      sel_o,
  output logic [7:0]                rdata_o,
  output logic [ADDR_W-1:WIN_LSB]   base_o
);
  localparam int NBYTES = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] WR_MASK = {{(ADDR_W-WIN_LSB){1'b1}}, {WIN_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] IO_FLAG = ADDR_W'(1);

  logic [ADDR_W-1:0] bar_q;
  logic [ADDR_W-1:0] bar_view;

  assign sel_o = (addr_i[7:2] == OFF_IOBAR[7:2]);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bar_q[8*b +: 8] <= 8'h00;
      else if (wr_i && sel_o && (addr_i[1:0] == 2'(b)))
        bar_q[8*b +: 8] <= wdata_i & WR_MASK[8*b +: 8];
    end
  end

  assign bar_view = (bar_q & WR_MASK) | IO_FLAG;
  assign rdata_o  = bar_view[8*addr_i[1:0] +: 8];
  assign base_o   = bar_q[ADDR_W-1:WIN_LSB];
endmodule

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 5
) (
  input  logic [ADDR_W-1:WIN_LSB] base_i,
  input  logic [ADDR_W-1:WIN_LSB] bus_addr_i,
  input  logic [3:0]              bus_cmd_i,
  input  logic                    addr_phase_i,
  input  logic                    io_en_i,
  output logic                    hit_o
);
  logic match;
  assign match = (bus_addr_i == base_i);
  assign hit_o = addr_phase_i && io_en_i && is_io_cmd(bus_cmd_i) && match;
endmodule

// File: rtl/cfg_io_hdr.sv
module cfg_io_hdr
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [7:0]              cfg_addr_i,
  input  logic                    cfg_rd_i,
  input  logic                    cfg_wr_i,
  input  logic [7:0]              cfg_wdata_i,
  output logic [7:0]              cfg_rdata_o,
  input  logic [ADDR_W-1:WIN_LSB] bus_addr_i,
  input  logic [3:0]              bus_cmd_i,
  input  logic                    addr_phase_i,
  input  logic                    io_en_i,
  output logic                    io_hit_o
);
  logic                    id_sel, bar_sel;
  logic [7:0]              id_data, bar_data, rd_d;
  logic [ADDR_W-1:WIN_LSB] base;

  cfg_id_rom u_id (
    .addr_i (cfg_addr_i),
    .sel_o  (id_sel),
    .data_o (id_data)
  );

  cfg_iobar_reg #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_bar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (cfg_addr_i),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .sel_o   (bar_sel),
    .rdata_o (bar_data),
    .base_o  (base)
  );

  io_addr_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_dec (
    .base_i       (base),
    .bus_addr_i   (bus_addr_i),
    .bus_cmd_i    (bus_cmd_i),
    .addr_phase_i (addr_phase_i),
    .io_en_i      (io_en_i),
    .hit_o        (io_hit_o)
  );

  // unimplemented offsets fall through to zero
  always_comb begin
    if (id_sel)       rd_d = id_data;
    else if (bar_sel) rd_d = bar_data;
    else              rd_d = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_rdata_o <= 8'h00;
    else if (cfg_rd_i) cfg_rdata_o <= rd_d;
    else               cfg_rdata_o <= 8'h00;
  end
endmodule

// File: rtl/cfg_io_hdr_chk.sv
module cfg_io_hdr_chk
  import cfg_hdr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] cfg_addr_i,
  input logic       cfg_rd_i,
  input logic [7:0] cfg_rdata_o,
  input logic [3:0] bus_cmd_i,
  input logic       addr_phase_i,
  input logic       io_en_i,
  input logic       io_hit_o
);
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> addr_phase_i); // R11
  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> io_en_i); // R9
  AST_HIT_IO_CMD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_hit_o |-> (bus_cmd_i == CMD_IO_RD || bus_cmd_i == CMD_IO_WR)); // R10
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rd_i |=> cfg_rdata_o == 8'h00); // R7
  AST_BASECLASS_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_addr_i == OFF_BASECLS) |=> cfg_rdata_o == 8'h02); // R2
  AST_HDRTYPE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_addr_i == OFF_HDRTYPE) |=> cfg_rdata_o == 8'h00); // R3
  AST_BAR_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_addr_i == OFF_IOBAR) |=> cfg_rdata_o[4:0] == 5'b00001); // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_addr_i == 8'h20) |=> cfg_rdata_o == 8'h00); // R6
endmodule

bind cfg_io_hdr cfg_io_hdr_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_rd_i     (cfg_rd_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .bus_cmd_i    (bus_cmd_i),
  .addr_phase_i (addr_phase_i),
  .io_en_i      (io_en_i),
  .io_hit_o     (io_hit_o)
);

// File: tb/cfg_io_hdr_test.sv
module cfg_io_hdr_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic        cfg_rd_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [26:0] bus_addr_i = '0;
  logic [3:0]  bus_cmd_i = '0;
  logic        addr_phase_i = 1'b0;
  logic        io_en_i = 1'b0;
  logic        io_hit_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] bar_m = 32'h0;  // bench model of the base (bits 31:5)

  cfg_io_hdr uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] exp_cfg(input logic [7:0] a);
    logic [31:0] v;
    v = (bar_m & 32'hFFFF_FFE0) | 32'h1;
    case (a)
      8'h09, 8'h0A, 8'h0E: return 8'h00;
      8'h0B: return 8'h02;
      8'h10: return v[7:0];
      8'h11: return v[15:8];
      8'h12: return v[23:16];
      8'h13: return v[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_hit(input logic [26:0] a, input logic [3:0] c,
                                   input logic en, input logic st);
    return st && en && (c == 4'b0010 || c == 4'b0011) && (a == bar_m[31:5]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    if (a >= 8'h10 && a <= 8'h13) bar_m[8*(a-8'h10) +: 8] = d & ((a == 8'h10) ? 8'hE0 : 8'hFF);
  endtask

  task automatic cfg_read(input logic [7:0] a, input string req);
    @(negedge clk_i);
    cfg_addr_i = a; cfg_rd_i = 1'b1;
    @(negedge clk_i);
    cfg_rd_i = 1'b0;
    check(req, 32'(cfg_rdata_o), 32'(exp_cfg(a)));
  endtask

  task automatic bus_try(input logic [26:0] a, input logic [3:0] c,
                         input logic en, input logic st, input string req);
    @(negedge clk_i);
    bus_addr_i = a; bus_cmd_i = c; io_en_i = en; addr_phase_i = st;
    #5;
    check(req, 32'(io_hit_o), 32'(exp_hit(a, c, en, st)));
    @(negedge clk_i);
    addr_phase_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] offs [12];
    offs = '{8'h09, 8'h0A, 8'h0B, 8'h0E, 8'h10, 8'h11, 8'h12, 8'h13,
             8'h00, 8'h0D, 8'h14, 8'h3C};
    void'($urandom(32'd20240611));
    #35;
    check("R1 rdata reset", 32'(cfg_rdata_o), 32'h0);
    rst_ni = 1'b1;
    // R1 reset state of base
    cfg_read(8'h10, "R1 bar byte0");
    cfg_read(8'h13, "R1 bar byte3");
    bus_try(27'h0, 4'b0010, 1'b1, 1'b1, "R1 R8 hit at zero base");
    // R2 identity bytes, writes ignored
    cfg_write(8'h0B, 8'hFF);
    cfg_read(8'h0B, "R2 baseclass");
    cfg_write(8'h0A, 8'h5A);
    cfg_read(8'h0A, "R2 subclass");
    cfg_read(8'h09, "R2 prog if");
    // R3 header type
    cfg_write(8'h0E, 8'h80);
    cfg_read(8'h0E, "R3 header type");
    // R4 R5 base programming
    cfg_write(8'h10, 8'hFF);
    cfg_write(8'h11, 8'hA5);
    cfg_write(8'h12, 8'h3C);
    cfg_write(8'h13, 8'hC3);
    cfg_read(8'h10, "R5 bar low bits");
    cfg_read(8'h11, "R4 bar byte1");
    cfg_read(8'h13, "R4 bar byte3");
    // R6 unimplemented
    cfg_write(8'h20, 8'h77);
    cfg_write(8'h14, 8'h77);
    cfg_read(8'h20, "R6 unimpl read");
    cfg_read(8'h12, "R6 bar unchanged");
    // R7 idle read data zero
    @(negedge clk_i);
    #1;
    check("R7 idle rdata", 32'(cfg_rdata_o), 32'h0);
    // R8..R11 directed
    bus_try(bar_m[31:5], 4'b0011, 1'b1, 1'b1, "R8 io write hit");
    bus_try(bar_m[31:5], 4'b0010, 1'b0, 1'b1, "R9 disabled");
    bus_try(bar_m[31:5], 4'b0110, 1'b1, 1'b1, "R10 memory read");
    bus_try(bar_m[31:5], 4'b1011, 1'b1, 1'b1, "R10 config write");
    bus_try(bar_m[31:5], 4'b0010, 1'b1, 1'b0, "R11 no strobe");
    bus_try(bar_m[31:5] ^ 27'h1, 4'b0010, 1'b1, 1'b1, "R8 near miss");
    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 2);
      if (k == 0) begin
        logic [7:0] a;
        a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : offs[$urandom_range(0, 11)];
        cfg_write(a, 8'($urandom));
      end else if (k == 1) begin
        logic [7:0] a;
        a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : offs[$urandom_range(0, 11)];
        cfg_read(a, "R2 R4 R5 R6 R7 random read");
      end else begin
        logic [26:0] a;
        a = $urandom_range(0, 1) ? bar_m[31:5] : 27'($urandom);
        bus_try(a, 4'($urandom), 1'($urandom), 1'($urandom), "R8 R9 R10 R11 random bus");
      end
    end
    finish_run();
  end
endmodule